// File: doc/BRIEF.md
# Per-Region Variable-Latency Bank Timer

This block guards the timing of a single DRAM bank when the activation-to-read delay and the precharge-to-activation delay differ from one memory region to the next. The two delays are not fixed parameters. A small profile table gives every region its own latency class for each delay, so a region known to hold no slow cells can run with shorter delays. A region that does hold slow cells keeps a longer, safe delay. Requests carry no latency hint: the class comes only from the row address, so software sees no change.

A scheduler offers one command at a time on the request port: open a row, read a column, or close the bank. The block grants the command in the same cycle once the delay for the targeted region has passed. It flags commands that make no sense for the current bank state, such as a read to a closed bank or an open to a bank that is already open. The profile table is loaded through a separate write port, normally after the memory has been characterised. All delays are counted in controller cycles of 2.5 ns. A 7.5 ns class is 3 cycles, a 10 ns class is 4 cycles, and the 13 ns standard class rounds up to 6 cycles.

Top module: `vlat_bank_timer`

## Requirements
- R1: After reset the bank is closed (`bank_open`=0, `rd_ready`=0), every region holds the standard class for both delays, and an open request to any row is ready at once (`act_ready`=1).
- R2: A 2-bit class code sets the delay in cycles as follows: 2'b00 gives 6 cycles, 2'b01 gives 4, 2'b10 gives 3, and the spare code 2'b11 gives 6.
- R3: A read is granted exactly N cycles after the grant of the open command, where N comes from the activation class of the opened row's region as it stood when the open was granted. A granted read drives its column on `rd_col`.
- R4: An open request is granted exactly N cycles after the grant of the last close that shut the bank, where N comes from the precharge class of the region of the row being opened.
- R5: The region of a row is its upper 4 row-address bits, which index a 16-entry table. Each entry holds a separate activation class and precharge class. A table write affects lookups from the next cycle on.
- R6: A read to a closed bank, or an open to an open bank, raises `req_error` for that cycle. It is not granted and leaves `bank_open` and `open_row` unchanged.
- R7: A close is granted at once. On an open bank it closes the bank and starts the precharge window. On a closed bank it changes nothing and does not restart the window.
- R8: A granted open sets `bank_open` and latches the row on `open_row`. A granted read leaves both unchanged.
- R9: Op codes are 2'b01 open, 2'b10 read, 2'b11 close, and 2'b00 none. With `req_valid` low, or with op 2'b00, neither grant nor error is raised. Grant and error are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one cycle per 2.5 ns step |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A command is offered this cycle |
| req_op | input | 2 | Command code (see R9) |
| req_row | input | ROW_W | Target row; its upper bits select the region |
| req_col | input | COL_W | Target column for a read |
| req_grant | output | 1 | Command accepted; it issues at the next clock edge |
| req_error | output | 1 | Command illegal for the bank state; dropped |
| prof_we | input | 1 | Write one profile entry |
| prof_idx | input | REGION_W | Region index to write |
| prof_rcd_cls | input | 2 | Activation-to-read class for that region |
| prof_rp_cls | input | 2 | Precharge-to-activation class for that region |
| act_ready | output | 1 | An open to `req_row` would be granted now |
| rd_ready | output | 1 | A read to the open row would be granted now |
| bank_open | output | 1 | A row is open in the bank |
| open_row | output | ROW_W | Row currently open |
| rd_col | output | COL_W | Column of the read granted this cycle, else zero |

## Verification
The hardest situation to reach from the ports is a profile write that lands inside a running precharge window. Such a write must shorten that window for the pending open in the following cycle, but not in the cycle of the write. The bench closes a bank in a standard-class region and keeps offering an open. In the third waiting cycle it writes the fast class for that region and confirms the open is refused then and granted one cycle later. All sixteen regions are then swept so that each pairing of activation and precharge class codes is measured as a grant delay. A close to an already closed bank is checked by showing that a following open is not delayed.

// File: rtl/vlat_pkg.sv
// Shared types for the per-region variable-latency bank timer.
// Assumes a 2-bit latency class code and a 2-bit command code.
package vlat_pkg;

    typedef enum logic [1:0] {
        LAT_STD  = 2'b00,
        LAT_SAFE = 2'b01,
        LAT_FAST = 2'b10,
        LAT_RSV  = 2'b11
    } lat_cls_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_OPEN  = 2'b01,
        OP_READ  = 2'b10,
        OP_CLOSE = 2'b11
    } bank_op_e;

    typedef struct packed {
        lat_cls_e rcd;
        lat_cls_e rp;
    } region_prof_t;

    // Map a class code to a cycle count; the spare code falls back to standard.
    function automatic int unsigned cls_to_cycles(
        input lat_cls_e    cls,
        input int unsigned std_c,
        input int unsigned safe_c,
        input int unsigned fast_c
    );
        case (cls)
            LAT_SAFE: return safe_c;
            LAT_FAST: return fast_c;
            default:  return std_c;
        endcase
    endfunction

endpackage

// File: rtl/vlat_profile_table.sv
// Region profile table: one activation class and one precharge class per region.
// Assumes writes take effect at the next clock edge; every entry resets to standard.
module vlat_profile_table
    import vlat_pkg::*;
#(
    parameter int REGION_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REGION_W-1:0] wr_idx,
    input  lat_cls_e            wr_rcd,
    input  lat_cls_e            wr_rp,
    input  logic [REGION_W-1:0] lk_idx,
    output region_prof_t        lk_prof
);
    localparam int NREG = 1 << REGION_W;

    region_prof_t tbl [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        // Hold one region's classes; reset to the standard class.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[g] <= '{rcd: LAT_STD, rp: LAT_STD};
            end else if (wr_en && (wr_idx == REGION_W'(g))) begin
                tbl[g] <= '{rcd: wr_rcd, rp: wr_rp};
            end
        end
    end

    // Combinational lookup for the row currently offered.
    always_comb lk_prof = tbl[lk_idx];

endmodule

// File: rtl/vlat_rp_window.sv
// Precharge window: counts cycles since the bank was last closed, saturating.
// The required count is supplied per request, so the class of the row about
// to be opened decides the window, not the class known at close time.
module vlat_rp_window #(
    parameter int CNT_W = 3,
    parameter int SAT   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] need,
    output logic             met
);
    logic [CNT_W-1:0] elapsed_q;

    // Count cycles since the close; after reset the bank counts as long precharged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= CNT_W'(SAT);
        end else if (restart) begin
            elapsed_q <= CNT_W'(1);
        end else if (elapsed_q < CNT_W'(SAT)) begin
            elapsed_q <= elapsed_q + CNT_W'(1);
        end
    end

    // Window met once the elapsed count reaches the requested delay.
    always_comb met = (elapsed_q >= need);

endmodule

// File: rtl/vlat_rcd_timer.sv
// Activation down-counter: loaded with the class delay when a row is opened.
// Assumes the load value is at least 1; expiry means a read may issue now.
module vlat_rcd_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cycles,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load delay-1 at the open edge so the read issues exactly 'cycles' later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cycles - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Expired when the counter has run down to zero.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/vlat_bank_timer.sv
// Per-region variable-latency bank timer (top).
// Grants open, read and close commands for one bank, enforcing the
// activation-to-read and precharge-to-activation delays looked up per region
// of the row address. Assumes one command offered per cycle; a grant issues
// at the next clock edge.
module vlat_bank_timer
    import vlat_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int COL_W    = 7,
    parameter int REGION_W = 4,
    parameter int CYC_STD  = 6,
    parameter int CYC_SAFE = 4,
    parameter int CYC_FAST = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ROW_W-1:0]    req_row,
    input  logic [COL_W-1:0]    req_col,
    output logic                req_grant,
    output logic                req_error,
    input  logic                prof_we,
    input  logic [REGION_W-1:0] prof_idx,
    input  logic [1:0]          prof_rcd_cls,
    input  logic [1:0]          prof_rp_cls,
    output logic                act_ready,
    output logic                rd_ready,
    output logic                bank_open,
    output logic [ROW_W-1:0]    open_row,
    output logic [COL_W-1:0]    rd_col
);
    localparam int CYC_HI  = (CYC_STD > CYC_SAFE) ? CYC_STD : CYC_SAFE;
    localparam int CYC_MAX = (CYC_HI > CYC_FAST) ? CYC_HI : CYC_FAST;
    localparam int CNT_W   = $clog2(CYC_MAX + 1);

    bank_op_e            op;
    logic [REGION_W-1:0] region;
    region_prof_t        prof;
    logic [CNT_W-1:0]    rcd_cyc;
    logic [CNT_W-1:0]    rp_cyc;
    logic                rp_met;
    logic                rcd_expired;
    logic                open_q;
    logic [ROW_W-1:0]    row_q;
    logic                do_open;
    logic                do_close;

    // Decode the offered command and its region.
    always_comb begin
        op     = bank_op_e'(req_op);
        region = req_row[ROW_W-1 -: REGION_W];
    end

    vlat_profile_table #(
        .REGION_W (REGION_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prof_we),
        .wr_idx  (prof_idx),
        .wr_rcd  (lat_cls_e'(prof_rcd_cls)),
        .wr_rp   (lat_cls_e'(prof_rp_cls)),
        .lk_idx  (region),
        .lk_prof (prof)
    );

    // Turn the looked-up classes into cycle counts.
    always_comb begin
        rcd_cyc = CNT_W'(cls_to_cycles(prof.rcd, CYC_STD, CYC_SAFE, CYC_FAST));
        rp_cyc  = CNT_W'(cls_to_cycles(prof.rp,  CYC_STD, CYC_SAFE, CYC_FAST));
    end

    vlat_rp_window #(
        .CNT_W (CNT_W),
        .SAT   (CYC_MAX)
    ) u_rp (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_close),
        .need    (rp_cyc),
        .met     (rp_met)
    );

    vlat_rcd_timer #(
        .CNT_W (CNT_W)
    ) u_rcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (do_open),
        .cycles  (rcd_cyc),
        .expired (rcd_expired)
    );

    // Readiness as seen by the scheduler.
    always_comb begin
        act_ready = !open_q && rp_met;
        rd_ready  = open_q && rcd_expired;
    end

    // Grant or reject the offered command against bank state and timers.
    always_comb begin
        req_grant = 1'b0;
        req_error = 1'b0;
        if (req_valid) begin
            case (op)
                OP_OPEN: begin
                    req_error = open_q;
                    req_grant = act_ready;
                end
                OP_READ: begin
                    req_error = !open_q;
                    req_grant = rd_ready;
                end
                OP_CLOSE: req_grant = 1'b1;
                default: ;
            endcase
        end
    end

    // Qualified state-changing events.
    always_comb begin
        do_open  = req_grant && (op == OP_OPEN);
        do_close = req_grant && (op == OP_CLOSE) && open_q;
        rd_col   = (req_grant && (op == OP_READ)) ? req_col : '0;
    end

    // Track which row, if any, is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (do_open) begin
            open_q <= 1'b1;
            row_q  <= req_row;
        end else if (do_close) begin
            open_q <= 1'b0;
        end
    end

    // Expose bank state.
    always_comb begin
        bank_open = open_q;
        open_row  = row_q;
    end

endmodule

// File: rtl/vlat_bank_timer_chk.sv
// Property checker for the variable-latency bank timer, bound to the top.
// Keeps its own cycle counters since the last open and close to bound gaps.
module vlat_bank_timer_chk #(
    parameter int ROW_W    = 10,
    parameter int CYC_STD  = 6,
    parameter int CYC_SAFE = 4,
    parameter int CYC_FAST = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [ROW_W-1:0] req_row,
    input logic             req_grant,
    input logic             req_error,
    input logic             rd_ready,
    input logic             bank_open,
    input logic [ROW_W-1:0] open_row
);
    localparam int CYC_LO  = (CYC_STD < CYC_SAFE) ? CYC_STD : CYC_SAFE;
    localparam int CYC_MIN = (CYC_LO < CYC_FAST) ? CYC_LO : CYC_FAST;
    localparam int CYC_HI  = (CYC_STD > CYC_SAFE) ? CYC_STD : CYC_SAFE;
    localparam int CYC_MAX = (CYC_HI > CYC_FAST) ? CYC_HI : CYC_FAST;
    localparam int CW      = $clog2(CYC_MAX + 1);

    logic          g_open;
    logic          g_read;
    logic          g_close;
    logic [CW-1:0] since_open;
    logic [CW-1:0] since_close;

    // Classify granted commands.
    always_comb begin
        g_open  = req_grant && (req_op == 2'b01);
        g_read  = req_grant && (req_op == 2'b10);
        g_close = req_grant && (req_op == 2'b11) && bank_open;
    end

    // Saturating cycle counts since the last open and the last real close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_open  <= CW'(CYC_MAX);
            since_close <= CW'(CYC_MAX);
        end else begin
            since_open  <= g_open  ? CW'(1) :
                           (since_open  < CW'(CYC_MAX) ? since_open  + CW'(1) : since_open);
            since_close <= g_close ? CW'(1) :
                           (since_close < CW'(CYC_MAX) ? since_close + CW'(1) : since_close);
        end
    end

    p_read_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        g_read |-> (since_open >= CW'(CYC_MIN)));

    p_open_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        g_open |-> (since_close >= CW'(CYC_MIN)));

    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_error |=> ($stable(bank_open) && $stable(open_row)));

    p_rd_needs_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> bank_open);

    p_close_shuts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        g_close |=> !bank_open);

    p_open_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        g_open |=> (bank_open && (open_row == $past(req_row))));

    p_no_dual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_grant && req_error));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_grant && !req_error));

endmodule

bind vlat_bank_timer vlat_bank_timer_chk #(
    .ROW_W    (ROW_W),
    .CYC_STD  (CYC_STD),
    .CYC_SAFE (CYC_SAFE),
    .CYC_FAST (CYC_FAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_row   (req_row),
    .req_grant (req_grant),
    .req_error (req_error),
    .rd_ready  (rd_ready),
    .bank_open (bank_open),
    .open_row  (open_row)
);

// File: tb/vlat_bank_timer_tb.sv
// Bench for the variable-latency bank timer: sweeps all 16 regions with every
// class pairing and measures grant delays against the class table.
module vlat_bank_timer_tb;
    localparam int CLK_P = 10;
    localparam int ROW_W = 10;
    localparam int COL_W = 7;
    localparam logic [1:0] OPN = 2'b01, RD = 2'b10, CLS = 2'b11, NON = 2'b00;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [1:0]       req_op;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             req_grant, req_error;
    logic             prof_we;
    logic [3:0]       prof_idx;
    logic [1:0]       prof_rcd_cls, prof_rp_cls;
    logic             act_ready, rd_ready, bank_open;
    logic [ROW_W-1:0] open_row;
    logic [COL_W-1:0] rd_col;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    vlat_bank_timer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_row(req_row), .req_col(req_col), .req_grant(req_grant),
        .req_error(req_error), .prof_we(prof_we), .prof_idx(prof_idx),
        .prof_rcd_cls(prof_rcd_cls), .prof_rp_cls(prof_rp_cls),
        .act_ready(act_ready), .rd_ready(rd_ready), .bank_open(bank_open),
        .open_row(open_row), .rd_col(rd_col)
    );

    // Expected delay of a class code (R2).
    function automatic int cyc_of(input int c);
        case (c)
            1: return 4;
            2: return 3;
            default: return 6;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Offer a command from just after an edge; sample at the falling edge.
    task automatic offer(input logic [1:0] op, input logic [ROW_W-1:0] row,
                         input logic [COL_W-1:0] col);
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = op; req_row = row; req_col = col;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            req_valid = 1'b0; req_op = NON; prof_we = 1'b0;
        end
        @(negedge clk);
    endtask

    // Keep offering a command; return the window index of its first grant.
    task automatic poll(input logic [1:0] op, input logic [ROW_W-1:0] row,
                        input logic [COL_W-1:0] col, output int k);
        k = 0;
        for (int i = 1; i <= 12; i++) begin
            offer(op, row, col);
            if (req_grant) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic write_prof(input int idx, input int rcd, input int rp);
        @(posedge clk); #1;
        prof_we = 1'b1; prof_idx = 4'(idx);
        prof_rcd_cls = 2'(rcd); prof_rp_cls = 2'(rp);
        @(posedge clk); #1;
        prof_we = 1'b0;
    endtask

    initial begin
        int k;
        logic [ROW_W-1:0] row;
        rst_n = 1'b0; req_valid = 1'b0; req_op = NON; req_row = '0; req_col = '0;
        prof_we = 1'b0; prof_idx = '0; prof_rcd_cls = '0; prof_rp_cls = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bank_open after reset", bank_open, 0);
        chk("R1 rd_ready after reset", rd_ready, 0);
        chk("R1 act_ready after reset", act_ready, 1);

        // R6: read to a closed bank.
        offer(RD, 10'h012, 7'h05);
        chk("R6 read-closed error", req_error, 1);
        chk("R6 read-closed grant", req_grant, 0);
        idle(1);
        chk("R6 read-closed keeps bank closed", bank_open, 0);

        // R9: idle and no-op codes.
        req_valid = 1'b0; req_op = OPN; #1;
        chk("R9 invalid open no grant", req_grant, 0);
        chk("R9 invalid open no error", req_error, 0);
        offer(NON, 10'h000, 7'h00);
        chk("R9 no-op no grant", req_grant, 0);
        chk("R9 no-op no error", req_error, 0);

        // R1: standard class at reset: open region 3, read after 6.
        row = {4'd3, 6'h11};
        offer(OPN, row, 7'h00);
        chk("R1 open granted after reset", req_grant, 1);
        poll(RD, row, 7'h2a, k);
        chk("R1 default activation delay", k, 6);
        offer(CLS, row, 7'h00);
        poll(OPN, row, 7'h00, k);
        chk("R1 default precharge delay", k, 6);
        offer(CLS, row, 7'h00);
        idle(8);

        // Sweep: region r gets activation class r%4 and precharge class r/4.
        for (int r = 0; r < 16; r++) begin
            int a = r % 4;
            int b = r / 4;
            logic [ROW_W-1:0] other;
            row   = {4'(r), 6'(r * 3 + 1)};
            other = {4'(r), 6'(r * 3 + 2)};
            write_prof(r, a, b);
            idle(8);
            offer(OPN, row, 7'h00);
            chk($sformatf("R4 rested open region %0d", r), req_grant, 1);
            poll(RD, row, 7'(r + 7), k);
            chk($sformatf("R3 R2 activation delay region %0d class %0d", r, a),
                k, cyc_of(a));
            chk($sformatf("R3 rd_col region %0d", r), rd_col, r + 7);
            chk($sformatf("R8 open_row region %0d", r), open_row, row);
            offer(OPN, other, 7'h00);
            chk($sformatf("R6 open-open error region %0d", r), req_error, 1);
            chk($sformatf("R6 open-open grant region %0d", r), req_grant, 0);
            idle(1);
            chk($sformatf("R6 open_row kept region %0d", r), open_row, row);
            chk($sformatf("R8 read keeps bank open region %0d", r), bank_open, 1);
            offer(CLS, row, 7'h00);
            chk($sformatf("R7 close granted region %0d", r), req_grant, 1);
            poll(OPN, row, 7'h00, k);
            chk($sformatf("R4 R2 precharge delay region %0d class %0d", r, b),
                k, cyc_of(b));
            offer(CLS, row, 7'h00);
            idle(1);
            chk($sformatf("R7 bank closed region %0d", r), bank_open, 0);
        end

        // R7: close on a closed bank does not restart the window (region 0 is standard).
        idle(8);
        offer(CLS, 10'h001, 7'h00);
        chk("R7 close on closed bank granted", req_grant, 1);
        offer(OPN, 10'h001, 7'h00);
        chk("R7 no window restart", req_grant, 1);
        chk("R8 open after idle close", act_ready, 1);

        // R5: table write inside a running precharge window (region 15 is standard).
        row = {4'd15, 6'h05};
        offer(CLS, 10'h001, 7'h00);
        idle(8);
        offer(OPN, row, 7'h00);
        poll(RD, row, 7'h00, k);
        offer(CLS, row, 7'h00);
        offer(OPN, row, 7'h00);
        chk("R5 window 1 not ready", act_ready, 0);
        offer(OPN, row, 7'h00);
        chk("R5 window 2 not ready", act_ready, 0);
        @(posedge clk); #1;
        prof_we = 1'b1; prof_idx = 4'd15; prof_rcd_cls = 2'b10; prof_rp_cls = 2'b10;
        @(negedge clk);
        chk("R5 write not yet visible", act_ready, 0);
        @(posedge clk); #1;
        prof_we = 1'b0;
        @(negedge clk);
        chk("R5 write visible next cycle", act_ready, 1);
        chk("R5 open granted after write", req_grant, 1);
        poll(RD, row, 7'h00, k);
        chk("R5 new activation class used", k, 3);
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule